// File: doc/BRIEF.md
# Receiver Lock Detect Controller

This block sits beside the reclocker of a serial video receiver. It chooses the data rate the reclocker tries, either SD (270 Mb/s) or HD (1.485 Gb/s). It also decides when the received stream counts as locked, and it mutes the parallel data outputs until lock is reached. Its inputs are control and status pins only: a carrier-present flag, a master/slave mode pin, a rate pin for slave mode, a DVB-ASI mode flag, a data-through flag, an analog-lock flag, and one-cycle pulses from external SMPTE TRS and DVB-ASI sync-word detectors.

In master mode, once a carrier is present, the block runs a hunt. The hunt has `HUNT_ATTEMPTS` attempts, each `ATTEMPT_CYCLES` clocks long, and the rate changes between SD and HD from one attempt to the next. When the last attempt ends, the hunt starts again from the first. A sync pulse during an attempt locks the block and holds the current rate. While locked, a gap of `LOSS_CYCLES` clocks with no sync pulse sends the block back to the hunt. Losing the carrier sends it back to the no-carrier state.

In slave mode, the rate comes straight from the rate pin. In data-through mode, the sync pulses are ignored and the lock flag follows the analog-lock input. Every output is a register, so each one reflects the inputs sampled at the previous clock edge.

Top module: `lkd_lock_ctrl`

## Requirements
- R1: While reset is asserted, `locked` is 0, `mute` is 1, `rate_hd` is 0 (SD) and `center_req` is 1.
- R2: One cycle after `carrier_n` is sampled high, `center_req` is 1 and `locked` is 0. One cycle after it is sampled low, `center_req` is 0.
- R3: `mute` equals the inverse of `locked`. The exception is when `master_mode` is 0 and `asi_mode` is 1: then `mute` is 0 one cycle later, even with no carrier.
- R4: With `master_mode` at 1 (master), a valid carrier and no sync pulses, the hunt starts at attempt 0. Each attempt lasts `ATTEMPT_CYCLES` clocks. `rate_hd` is 0 in even attempts and 1 in odd attempts. After attempt `HUNT_ATTEMPTS-1` the hunt wraps back to attempt 0.
- R5: During the hunt, a pulse on `trs_hit` or `asi_hit` sets `locked` to 1 in the next cycle. In master mode, `rate_hd` keeps the value it had in the attempt where the pulse arrived.
- R6: With `master_mode` at 0 (slave), `rate_hd` equals `slave_hd` as sampled one cycle earlier (1 = HD), in every state.
- R7: While locked, `LOSS_CYCLES` consecutive cycles without a sync pulse clear `locked` and restart the hunt at attempt 0. Any sync pulse in that window starts the count again.
- R8: When the carrier is lost while locked, `locked` clears in the next cycle. When the carrier returns, the hunt restarts at attempt 0.
- R9: With `bypass` at 1 and a valid carrier, `locked` equals `analog_lock` one cycle later and the sync pulses have no effect. Leaving bypass puts the block in the hunt at attempt 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_n | input | 1 | Low when a valid serial input is present |
| master_mode | input | 1 | 1 = master (hunting), 0 = slave (fixed rate) |
| slave_hd | input | 1 | Slave-mode rate choice, 1 = HD |
| asi_mode | input | 1 | DVB-ASI stream selected |
| bypass | input | 1 | Data-through mode: sync checking off |
| analog_lock | input | 1 | Analog PLL lock flag |
| trs_hit | input | 1 | One-cycle SMPTE TRS sync-word pulse |
| asi_hit | input | 1 | One-cycle DVB-ASI sync-word pulse |
| rate_hd | output | 1 | Reclocker rate selection, 1 = HD, 0 = SD |
| center_req | output | 1 | Request for the centre of the pull range |
| locked | output | 1 | Lock indication |
| mute | output | 1 | Mute enable for the parallel data outputs |

## Verification
The hardest situation to reach is a loss of lock that lands on a particular hunt attempt, where the rate on re-entry must be SD no matter which attempt produced the lock. The stimulus first lets the hunt pass through every attempt and wrap around. It then places a TRS pulse inside an HD attempt and keeps the lock alive with DVB-ASI pulses spaced closer than the loss window. After that it stops the pulses and counts the clocks exactly to the loss boundary, one cycle short of it and then on it. A behavioural model in the bench, running from the same pins, follows every one of these steps on every clock.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  typedef enum logic [1:0] {
    ST_NOCAR = 2'd0,
    ST_HUNT  = 2'd1,
    ST_LOCK  = 2'd2
  } lkd_state_e;

  function automatic int lkd_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lkd_attempt_seq.sv
module lkd_attempt_seq #(
  parameter int ATTEMPT_CYCLES = 64,
  parameter int HUNT_ATTEMPTS  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic hd_d
);
  localparam int TW = lkd_pkg::lkd_width(ATTEMPT_CYCLES);
  localparam int AW = lkd_pkg::lkd_width(HUNT_ATTEMPTS);

  logic [TW-1:0] tmr_q, tmr_d;
  logic [AW-1:0] att_q, att_d;

  always_comb begin
    tmr_d = tmr_q;
    att_d = att_q;
    if (clr) begin
      tmr_d = '0;
      att_d = '0;
    end else if (run) begin
      if (tmr_q == TW'(ATTEMPT_CYCLES - 1)) begin
        tmr_d = '0;
        att_d = (att_q == AW'(HUNT_ATTEMPTS - 1)) ? '0 : att_q + AW'(1);
      end else begin
        tmr_d = tmr_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      att_q <= '0;
    end else begin
      tmr_q <= tmr_d;
      att_q <= att_d;
    end
  end

  assign hd_d = att_d[0];
endmodule

// File: rtl/lkd_loss_mon.sv
module lkd_loss_mon #(
  parameter int LOSS_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic at_limit
);
  localparam int CW = lkd_pkg::lkd_width(LOSS_CYCLES);

  logic [CW-1:0] cnt_q;

  assign at_limit = (cnt_q == CW'(LOSS_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= at_limit ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/lkd_lock_ctrl.sv
module lkd_lock_ctrl
  import lkd_pkg::*;
#(
  parameter int ATTEMPT_CYCLES = 64,
  parameter int LOSS_CYCLES    = 256,
  parameter int HUNT_ATTEMPTS  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_n,
  input  logic master_mode,
  input  logic slave_hd,
  input  logic asi_mode,
  input  logic bypass,
  input  logic analog_lock,
  input  logic trs_hit,
  input  logic asi_hit,
  output logic rate_hd,
  output logic center_req,
  output logic locked,
  output logic mute
);
  lkd_state_e state_q, state_d;
  logic sync_seen;
  logic seq_clr, seq_run, seq_hd_d;
  logic loss_clr, loss_run, loss_limit;
  logic locked_d;

  assign sync_seen = trs_hit | asi_hit;

  lkd_attempt_seq #(
    .ATTEMPT_CYCLES(ATTEMPT_CYCLES),
    .HUNT_ATTEMPTS (HUNT_ATTEMPTS)
  ) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (seq_clr),
    .run  (seq_run),
    .hd_d (seq_hd_d)
  );

  lkd_loss_mon #(
    .LOSS_CYCLES(LOSS_CYCLES)
  ) u_loss (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (loss_clr),
    .run     (loss_run),
    .at_limit(loss_limit)
  );

  always_comb begin
    state_d  = state_q;
    seq_clr  = 1'b0;
    seq_run  = 1'b0;
    loss_clr = 1'b1;
    loss_run = 1'b0;
    if (carrier_n) begin
      state_d = ST_NOCAR;
      seq_clr = 1'b1;
    end else if (bypass) begin
      state_d = ST_HUNT;
      seq_clr = 1'b1;
    end else begin
      unique case (state_q)
        ST_NOCAR: begin
          state_d = ST_HUNT;
          seq_clr = 1'b1;
        end
        ST_HUNT: begin
          if (sync_seen) state_d = ST_LOCK;
          else           seq_run = 1'b1;
        end
        ST_LOCK: begin
          if (!sync_seen) begin
            loss_clr = 1'b0;
            loss_run = 1'b1;
            if (loss_limit) begin
              state_d = ST_HUNT;
              seq_clr = 1'b1;
            end
          end
        end
        default: begin
          state_d = ST_NOCAR;
          seq_clr = 1'b1;
        end
      endcase
    end
  end

  assign locked_d = (!carrier_n && bypass) ? analog_lock : (state_d == ST_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_NOCAR;
      locked     <= 1'b0;
      mute       <= 1'b1;
      rate_hd    <= 1'b0;
      center_req <= 1'b1;
    end else begin
      state_q    <= state_d;
      locked     <= locked_d;
      mute       <= !locked_d && !(!master_mode && asi_mode);
      rate_hd    <= master_mode ? seq_hd_d : slave_hd;
      center_req <= carrier_n;
    end
  end
endmodule

// File: rtl/lkd_lock_ctrl_chk.sv
module lkd_lock_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic carrier_n,
  input logic master_mode,
  input logic slave_hd,
  input logic asi_mode,
  input logic bypass,
  input logic analog_lock,
  input logic trs_hit,
  input logic asi_hit,
  input logic rate_hd,
  input logic center_req,
  input logic locked,
  input logic mute
);
  AST_NOCAR_CENTER: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_n |=> (center_req && !locked)); // R2
  AST_CARRIER_NO_CENTER: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier_n |=> !center_req); // R2
  AST_NOCAR_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier_n && (master_mode || !asi_mode)) |=> mute); // R3
  AST_SLAVE_ASI_UNMUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && asi_mode) |=> !mute); // R3
  AST_LOCK_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(bypass) || $past(trs_hit || asi_hit))); // R5
  AST_SLAVE_RATE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |=> (rate_hd == $past(slave_hd))); // R6
  AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!carrier_n && bypass) |=> (locked == $past(analog_lock))); // R9
endmodule

bind lkd_lock_ctrl lkd_lock_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .carrier_n  (carrier_n),
  .master_mode(master_mode),
  .slave_hd   (slave_hd),
  .asi_mode   (asi_mode),
  .bypass     (bypass),
  .analog_lock(analog_lock),
  .trs_hit    (trs_hit),
  .asi_hit    (asi_hit),
  .rate_hd    (rate_hd),
  .center_req (center_req),
  .locked     (locked),
  .mute       (mute)
);

// File: tb/tb_lkd_lock_ctrl.sv
module tb_lkd_lock_ctrl;
  localparam int A = 8;
  localparam int L = 12;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic carrier_n = 1'b1, master_mode = 1'b1, slave_hd = 1'b0, asi_mode = 1'b0;
  logic bypass = 1'b0, analog_lock = 1'b0, trs_hit = 1'b0, asi_hit = 1'b0;
  logic rate_hd, center_req, locked, mute;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_st = 0, m_att = 0, m_tmr = 0, m_loss = 0;
  bit e_locked = 1'b0, e_mute = 1'b1, e_rate = 1'b0, e_center = 1'b1;
  bit hit;

  always #5 clk = ~clk;

  lkd_lock_ctrl #(.ATTEMPT_CYCLES(A), .LOSS_CYCLES(L), .HUNT_ATTEMPTS(N)) dut (
    .clk(clk), .rst_n(rst_n), .carrier_n(carrier_n), .master_mode(master_mode),
    .slave_hd(slave_hd), .asi_mode(asi_mode), .bypass(bypass),
    .analog_lock(analog_lock), .trs_hit(trs_hit), .asi_hit(asi_hit),
    .rate_hd(rate_hd), .center_req(center_req), .locked(locked), .mute(mute)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // reference model: states 0 no carrier, 1 hunt, 2 locked
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_att = 0; m_tmr = 0; m_loss = 0;
      e_locked = 0; e_mute = 1; e_rate = 0; e_center = 1;
    end else begin
      hit = trs_hit || asi_hit;
      if (carrier_n) begin
        m_st = 0; m_att = 0; m_tmr = 0;
      end else if (bypass || m_st == 0) begin
        m_st = 1; m_att = 0; m_tmr = 0;
      end else if (m_st == 1) begin
        if (hit) begin
          m_st = 2; m_loss = 0;
        end else begin
          m_tmr++;
          if (m_tmr == A) begin m_tmr = 0; m_att = (m_att + 1) % N; end
        end
      end else begin
        if (hit) m_loss = 0;
        else begin
          m_loss++;
          if (m_loss == L) begin m_st = 1; m_att = 0; m_tmr = 0; end
        end
      end
      e_locked = (!carrier_n && bypass) ? analog_lock : (m_st == 2);
      e_mute   = !e_locked && !(!master_mode && asi_mode);
      e_rate   = master_mode ? (m_att % 2 == 1) : slave_hd;
      e_center = carrier_n;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(locked == e_locked, "R5 locked vs model", locked, e_locked);
      chk(mute == e_mute, "R3 mute vs model", mute, e_mute);
      chk(rate_hd == e_rate, "R4 rate vs model", rate_hd, e_rate);
      chk(center_req == e_center, "R2 center vs model", center_req, e_center);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    tick(3);
    chk(locked == 0 && mute == 1 && rate_hd == 0 && center_req == 1, "R1 reset values",
        {locked, mute, rate_hd, center_req}, 4'b0101);
    rst_n = 1'b1;
    tick(3);
    chk(center_req == 1 && locked == 0, "R2 no carrier", {center_req, locked}, 2'b10);

    // master hunt through all attempts and the wrap
    carrier_n = 1'b0;
    tick(1);
    chk(center_req == 0 && rate_hd == 0, "R2 carrier present, attempt 0 SD", {center_req, rate_hd}, 0);
    tick(A);
    chk(rate_hd == 1, "R4 attempt 1 HD", rate_hd, 1);
    tick(A);
    chk(rate_hd == 0, "R4 attempt 2 SD", rate_hd, 0);
    tick(A);
    chk(rate_hd == 1, "R4 attempt 3 HD", rate_hd, 1);
    tick(A);
    chk(rate_hd == 0, "R4 wrap to attempt 0", rate_hd, 0);

    // lock inside an HD attempt
    tick(A + 1);
    trs_hit = 1'b1; tick(1); trs_hit = 1'b0;
    chk(locked == 1 && rate_hd == 1 && mute == 0, "R5 lock holds HD", {locked, rate_hd, mute}, 3'b110);

    // keep alive, then loss window
    repeat (4) begin
      tick(4);
      asi_hit = 1'b1; tick(1); asi_hit = 1'b0;
    end
    chk(locked == 1, "R7 kept alive by pulses", locked, 1);
    tick(L - 1);
    chk(locked == 1, "R7 one short of window", locked, 1);
    tick(1);
    chk(locked == 0 && rate_hd == 0, "R7 loss restarts at attempt 0", {locked, rate_hd}, 0);

    // carrier loss while locked
    tick(2);
    trs_hit = 1'b1; tick(1); trs_hit = 1'b0;
    carrier_n = 1'b1; tick(1);
    chk(locked == 0 && center_req == 1 && mute == 1, "R8 carrier loss unlocks", {locked, center_req, mute}, 3'b011);
    carrier_n = 1'b0; tick(1);
    chk(rate_hd == 0 && locked == 0, "R8 restart attempt 0", {rate_hd, locked}, 0);
    tick(A);
    chk(rate_hd == 1, "R8 next attempt HD", rate_hd, 1);

    // slave mode
    master_mode = 1'b0; slave_hd = 1'b1; asi_mode = 1'b1; carrier_n = 1'b1;
    tick(1);
    chk(mute == 0, "R3 slave ASI unmuted without carrier", mute, 0);
    chk(rate_hd == 1, "R6 slave rate from pin", rate_hd, 1);
    carrier_n = 1'b0;
    tick(3 * A);
    chk(rate_hd == 1, "R6 slave no toggling", rate_hd, 1);
    asi_mode = 1'b0; carrier_n = 1'b1; tick(1);
    chk(mute == 1, "R3 slave non-ASI muted", mute, 1);
    carrier_n = 1'b0; slave_hd = 1'b0; tick(2);
    chk(rate_hd == 0, "R6 slave SD pin", rate_hd, 0);
    asi_hit = 1'b1; tick(1); asi_hit = 1'b0;
    chk(locked == 1 && rate_hd == 0, "R5 slave lock", {locked, rate_hd}, 2'b10);

    // data-through
    master_mode = 1'b1; bypass = 1'b1; analog_lock = 1'b1; tick(1);
    chk(locked == 1, "R9 follows analog lock high", locked, 1);
    analog_lock = 1'b0; trs_hit = 1'b1; tick(1); trs_hit = 1'b0;
    chk(locked == 0, "R9 sync ignored in bypass", locked, 0);
    analog_lock = 1'b1; tick(1);
    chk(locked == 1, "R9 follows analog lock again", locked, 1);
    bypass = 1'b0; tick(1);
    chk(locked == 0 && rate_hd == 0, "R9 exit bypass into hunt attempt 0", {locked, rate_hd}, 0);
    bypass = 1'b1; carrier_n = 1'b1; tick(1);
    chk(locked == 0 && center_req == 1, "R2 no carrier overrides bypass", {locked, center_req}, 2'b01);

    tick(2);
    finish_run();
  end
endmodule